// File: doc/BRIEF.md
# Posted Write Buffer with Line Burst Support

This block sits between a processor core and its external memory port and holds writes that have been posted but not yet completed, so the core keeps running while memory catches up. Three kinds of producer feed it: stores to uncached space, stores to write-through space, and dirty-line writebacks from the data cache. Every entry is an address, a data word and a byte-enable mask. Entries leave in arrival order through a valid/ready write port, one per accepted handshake.

A cache-line writeback is as long as the buffer is deep, so a line fills the buffer completely. A line may start only when the buffer is empty. Its entries are tagged as one burst and are not offered to memory until the whole line is inside. Single stores and whole lines can be mixed freely, and their order is kept. A read-ordering port compares a read address against every pending entry at word granularity. It raises a stall while any match remains queued.

Top module: `wbuf_top`

## Requirements
- R1: After reset the buffer reports empty_o=1 and full_o=0, mem_valid_o=0, hazard_o=0, and a single store request sees req_ready_o=1.
- R2: Kinds 0 (uncached) and 1 (write-through) are single stores, and kind 3 is treated the same way. Each one is accepted with its own address, data and byte enables. It leaves with mem_burst_o=0 and mem_last_o=0, in strict arrival order with respect to all other entries.
- R3: full_o is 1 exactly when DEPTH entries are held. While full_o=1, req_ready_o is 0 for single stores and the held count never exceeds DEPTH.
- R4: One entry leaves on each cycle with mem_valid_o=1 and mem_ready_i=1. While mem_valid_o=1 and mem_ready_i=0, the presented address, data, byte enables and flags stay unchanged on the next cycle.
- R5: The first beat of a line writeback (kind 2) is accepted only when empty_o=1. While the buffer is not empty, req_ready_o stays 0 for it.
- R6: A line is DEPTH consecutive kind-2 beats. Each beat is stored with all byte enables set and leaves with mem_burst_o=1. mem_last_o=1 only on the DEPTH-th beat.
- R7: No beat of a line is offered (mem_valid_o=0) until all DEPTH beats are held. After that, with mem_ready_i held at 1, the beats leave on consecutive cycles.
- R8: While a line is partly received, single stores see req_ready_o=0.
- R9: hazard_o=1 in the same cycle that rd_check_i=1 and rd_addr_i matches the address of a still-pending entry with the low log2(DW/8) byte-offset bits ignored. hazard_o returns to 0 once the matching entry has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Write request present |
| req_kind_i | input | 2 | 0 uncached, 1 write-through, 2 line beat, 3 single |
| req_addr_i | input | AW | Byte address of the write |
| req_data_i | input | DW | Write data |
| req_be_i | input | DW/8 | Byte enables (ignored for line beats) |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| mem_valid_o | output | 1 | Head entry offered to memory |
| mem_ready_i | input | 1 | Memory takes the head entry |
| mem_addr_o | output | AW | Head entry address |
| mem_data_o | output | DW | Head entry data |
| mem_be_o | output | DW/8 | Head entry byte enables |
| mem_burst_o | output | 1 | Head entry belongs to a line burst |
| mem_last_o | output | 1 | Head entry is the final beat of a burst |
| full_o | output | 1 | All entries occupied |
| empty_o | output | 1 | No entries occupied |
| rd_check_i | input | 1 | A read wants an ordering check |
| rd_addr_i | input | AW | Address of that read |
| hazard_o | output | 1 | Read must stall behind a pending write |

## Verification
The assertions check these rules on every cycle: no push into a full buffer and no pop from an empty one, a held count that matches the per-entry valid bits, presented outputs frozen while memory back-pressures, line starts only from empty, and back-to-back burst beats once a line is complete. They also check that a hazard never appears without an entry. Only the bench scenarios can show the data-level behaviours. These are the exact order of mixed single stores and lines through the scoreboard, the forced byte enables and the last-beat marking, and the stalls that single stores and lines see while a line is partly loaded. The word-granular matching of the hazard stall and its release after drain also depend on those scenarios.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    WK_UNCACHED = 2'd0,
    WK_WTHRU    = 2'd1,
    WK_LINE     = 2'd2,
    WK_SINGLE   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/wbuf_intake.sv
module wbuf_intake
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_kind_i,
  input  logic       empty_i,
  input  logic       full_i,
  output logic       req_ready_o,
  output logic       push_o,
  output logic       push_blk_o,
  output logic       push_last_o,
  output logic       line_open_o
);
  localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] beat_q;
  logic          open_q;
  logic          is_line;

  assign is_line = (req_kind_i == WK_LINE);

  // a line starts from empty; singles wait while a line is partly in
  always_comb begin
    if (is_line) req_ready_o = open_q | empty_i;
    else         req_ready_o = !open_q & !full_i;
  end

  assign push_o      = req_valid_i & req_ready_o;
  assign push_blk_o  = is_line;
  assign push_last_o = is_line & (beat_q == CW'(DEPTH-1));
  assign line_open_o = open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      open_q <= 1'b0;
    end else if (push_o && is_line) begin
      if (push_last_o) begin
        beat_q <= '0;
        open_q <= 1'b0;
      end else begin
        beat_q <= beat_q + CW'(1);
        open_q <= 1'b1;
      end
    end
  end

  // R6: beat counter only runs while a line is open
  a_r6_beat_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q |-> beat_q == '0);
endmodule

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int BEW   = DW/8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic [AW-1:0]             push_addr_i,
  input  logic [DW-1:0]             push_data_i,
  input  logic [BEW-1:0]            push_be_i,
  input  logic                      push_blk_i,
  input  logic                      push_last_i,
  input  logic                      pop_i,
  input  logic                      hold_blk_i,
  output logic                      head_valid_o,
  output logic [AW-1:0]             head_addr_o,
  output logic [DW-1:0]             head_data_o,
  output logic [BEW-1:0]            head_be_o,
  output logic                      head_blk_o,
  output logic                      head_last_o,
  output logic                      full_o,
  output logic                      empty_o,
  output logic [DEPTH-1:0]          vld_o,
  output logic [DEPTH-1:0][AW-1:0]  ent_addr_o
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH+1);

  typedef struct packed {
    logic [AW-1:0]  addr;
    logic [DW-1:0]  data;
    logic [BEW-1:0] be;
    logic           blk;
    logic           last;
  } ent_t;

  ent_t            ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0]   wr_q, rd_q;
  logic [CNW-1:0]  cnt_q;
  ent_t            head;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[gi] <= 1'b0;
          ent_q[gi] <= '0;
        end else begin
          if (push_i && wr_q == PW'(gi)) begin
            ent_q[gi] <= '{addr: push_addr_i, data: push_data_i, be: push_be_i,
                           blk: push_blk_i, last: push_last_i};
            vld_q[gi] <= 1'b1;
          end else if (pop_i && rd_q == PW'(gi)) begin
            vld_q[gi] <= 1'b0;
          end
        end
      end
      assign ent_addr_o[gi] = ent_q[gi].addr;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNW'(push_i) - CNW'(pop_i);
    end
  end

  assign head    = ent_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNW'(DEPTH));
  assign vld_o   = vld_q;

  // block beats wait until the whole line is inside
  assign head_valid_o = !empty_o && !(head.blk && hold_blk_i);
  assign head_addr_o  = head.addr;
  assign head_data_o  = head.data;
  assign head_be_o    = head.be;
  assign head_blk_o   = head.blk;
  assign head_last_o  = head.last;

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CNW'(DEPTH) || pop_i);
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> vld_q[rd_q]);
  a_r3_count_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(vld_q) == int'(cnt_q));
endmodule

// File: rtl/wbuf_hazard.sv
module wbuf_hazard #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int OFFB  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_check_i,
  input  logic [AW-1:0]            rd_addr_i,
  input  logic [DEPTH-1:0]         vld_i,
  input  logic [DEPTH-1:0][AW-1:0] ent_addr_i,
  input  logic                     empty_i,
  output logic                     hazard_o
);
  localparam logic [AW-1:0] WORD_MASK = ~AW'((64'd1 << OFFB) - 64'd1);

  logic [DEPTH-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign hit[gi] = vld_i[gi] && (((ent_addr_i[gi] ^ rd_addr_i) & WORD_MASK) == '0);
    end
  endgenerate

  assign hazard_o = rd_check_i && (|hit);

  a_r9_hazard_needs_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_o |-> !empty_i);
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int BEW   = DW/8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [1:0]      req_kind_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_data_i,
  input  logic [BEW-1:0]  req_be_i,
  output logic            req_ready_o,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_data_o,
  output logic [BEW-1:0]  mem_be_o,
  output logic            mem_burst_o,
  output logic            mem_last_o,
  output logic            full_o,
  output logic            empty_o,
  input  logic            rd_check_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic            hazard_o
);
  localparam int OFFB = (BEW > 1) ? $clog2(BEW) : 0;

  logic                     push, push_blk, push_last, line_open, pop;
  logic [BEW-1:0]           push_be;
  logic [DEPTH-1:0]         vld;
  logic [DEPTH-1:0][AW-1:0] ent_addr;

  wbuf_intake #(.DEPTH(DEPTH)) u_intake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .empty_i     (empty_o),
    .full_i      (full_o),
    .req_ready_o (req_ready_o),
    .push_o      (push),
    .push_blk_o  (push_blk),
    .push_last_o (push_last),
    .line_open_o (line_open)
  );

  // line beats always write the full word
  assign push_be = push_blk ? '1 : req_be_i;
  assign pop     = mem_valid_o & mem_ready_i;

  wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BEW(BEW)) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_addr_i  (req_addr_i),
    .push_data_i  (req_data_i),
    .push_be_i    (push_be),
    .push_blk_i   (push_blk),
    .push_last_i  (push_last),
    .pop_i        (pop),
    .hold_blk_i   (line_open),
    .head_valid_o (mem_valid_o),
    .head_addr_o  (mem_addr_o),
    .head_data_o  (mem_data_o),
    .head_be_o    (mem_be_o),
    .head_blk_o   (mem_burst_o),
    .head_last_o  (mem_last_o),
    .full_o       (full_o),
    .empty_o      (empty_o),
    .vld_o        (vld),
    .ent_addr_o   (ent_addr)
  );

  wbuf_hazard #(.DEPTH(DEPTH), .AW(AW), .OFFB(OFFB)) u_hazard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_check_i (rd_check_i),
    .rd_addr_i  (rd_addr_i),
    .vld_i      (vld),
    .ent_addr_i (ent_addr),
    .empty_i    (empty_o),
    .hazard_o   (hazard_o)
  );

  a_r1_status_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
      $stable(mem_data_o) && $stable(mem_be_o) && $stable(mem_last_o));
  a_r5_line_from_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push && push_blk && !line_open |-> empty_o);
  a_r7_burst_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i && mem_burst_o && !mem_last_o |=> mem_valid_o && mem_burst_o);
  a_r8_single_blocked_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_open && push |-> push_blk);
endmodule

// File: tb/tb_wbuf_top.sv
`timescale 1ns/1ps
module tb_wbuf_top;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int BEW = DW/8;
  localparam int EW = AW + DW + BEW + 2;

  logic clk = 0, rst_ni = 0;
  logic req_valid_i = 0;
  logic [1:0] req_kind_i = 0;
  logic [AW-1:0] req_addr_i = 0;
  logic [DW-1:0] req_data_i = 0;
  logic [BEW-1:0] req_be_i = 0;
  logic req_ready_o, mem_valid_o, mem_ready_i, mem_burst_o, mem_last_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_data_o;
  logic [BEW-1:0] mem_be_o;
  logic full_o, empty_o, hazard_o;
  logic rd_check_i = 0;
  logic [AW-1:0] rd_addr_i = 0;

  int checks = 0, fails = 0, cyc = 0, rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [EW-1:0] exp_q[$];
  logic mid_burst = 0;

  always #5 clk = ~clk;

  wbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*, .clk_i(clk));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // memory ready pattern, updated after the driver settles
  always @(posedge clk) begin
    #2;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: mem_ready_i = 0;
      1: mem_ready_i = 1;
      default: mem_ready_i = lfsr[0] | lfsr[3];
    endcase
  end

  // monitor: compares every drained entry with the scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (mid_burst && mem_ready_i)
        chk(mem_valid_o, "R7 burst gap", mem_valid_o, 1);
      if (mem_valid_o && mem_ready_i) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected drain", mem_addr_o, 0);
        else begin
          logic [EW-1:0] e;
          e = exp_q.pop_front();
          chk({mem_addr_o, mem_data_o, mem_be_o, mem_burst_o, mem_last_o} == e,
              e[1] ? "R6 line beat" : "R2 single order",
              {mem_addr_o, mem_data_o, mem_be_o, mem_burst_o, mem_last_o}, e);
        end
        mid_burst = mem_burst_o && !mem_last_o;
      end else if (mem_ready_i) mid_burst = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [BEW-1:0] be, input bit last);
    bit acc;
    req_valid_i = 1; req_kind_i = k; req_addr_i = a; req_data_i = d; req_be_i = be;
    do begin
      @(negedge clk);
      acc = req_ready_o;
      if (acc) begin
        if (k == 2) exp_q.push_back({a, d, {BEW{1'b1}}, 1'b1, last});
        else        exp_q.push_back({a, d, be, 1'b0, 1'b0});
      end
      @(posedge clk); #1;
    end while (!acc);
    req_valid_i = 0;
  endtask

  task automatic send_line(input logic [AW-1:0] base);
    for (int i = 0; i < DEPTH; i++)
      send(2, base + AW'(8*i), {32'hB0B0_0000, base + AW'(i)}, 8'h0F, i == DEPTH-1);
  endtask

  task automatic wait_empty();
    do @(negedge clk); while (!empty_o);
    @(posedge clk); #1;
  endtask

  initial begin
    logic [AW-1:0] held;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    chk(empty_o && !full_o && !mem_valid_o && !hazard_o && req_ready_o, "R1 reset state",
        {empty_o, full_o, mem_valid_o, hazard_o, req_ready_o}, 5'b10001);
    @(posedge clk); #1;

    // fill with singles, memory stalled
    send(0, 32'h1000, 64'h1111, 8'h01, 0);
    send(1, 32'h1008, 64'h2222, 8'h0C, 0);
    send(3, 32'h1010, 64'h3333, 8'hF0, 0);
    send(0, 32'h1018, 64'h4444, 8'hFF, 0);
    @(negedge clk);
    chk(full_o && !empty_o, "R3 full flag", {full_o, empty_o}, 2'b10);
    @(posedge clk); #1;
    req_valid_i = 1; req_kind_i = 0; req_addr_i = 32'h2000;
    @(negedge clk);
    chk(!req_ready_o, "R3 single stalled when full", req_ready_o, 0);
    @(posedge clk); #1;
    req_kind_i = 2;
    @(negedge clk);
    chk(!req_ready_o, "R5 line stalled when not empty", req_ready_o, 0);
    @(posedge clk); #1;
    req_valid_i = 0;
    rd_check_i = 1; rd_addr_i = 32'h1013;
    @(negedge clk);
    chk(hazard_o, "R9 word match", hazard_o, 1);
    @(posedge clk); #1;
    rd_addr_i = 32'h1020;
    @(negedge clk);
    chk(!hazard_o, "R9 no match", hazard_o, 0);
    held = mem_addr_o;
    chk(mem_valid_o && held == 32'h1000, "R4 head offered", held, 32'h1000);
    @(posedge clk); #1;
    rd_addr_i = 32'h1000;
    @(negedge clk);
    chk(mem_valid_o && mem_addr_o == held, "R4 held under backpressure", mem_addr_o, held);
    @(posedge clk); #1;
    rdy_mode = 1;
    wait_empty();
    @(negedge clk);
    chk(!hazard_o, "R9 cleared after drain", hazard_o, 0);
    @(posedge clk); #1;
    rd_check_i = 0;

    // line with gaps between beats
    send(2, 32'h3000, 64'hA0, 8'h00, 0);
    for (int g = 0; g < 2; g++) begin
      req_valid_i = 1; req_kind_i = 0; req_addr_i = 32'h4000;
      @(negedge clk);
      chk(!mem_valid_o, "R7 partial line not offered", mem_valid_o, 0);
      chk(!req_ready_o, "R8 single stalled during line", req_ready_o, 0);
      @(posedge clk); #1;
      req_valid_i = 0;
    end
    send(2, 32'h3008, 64'hA1, 8'h00, 0);
    send(2, 32'h3010, 64'hA2, 8'h00, 0);
    send(2, 32'h3018, 64'hA3, 8'h00, 1);
    wait_empty();

    // mixed order: singles, line waiting for empty, then single
    rdy_mode = 0;
    send(1, 32'h5000, 64'h55, 8'h03, 0);
    send(0, 32'h5008, 64'h66, 8'h80, 0);
    fork
      begin send_line(32'h6000); send(0, 32'h7000, 64'h77, 8'h10, 0); end
      begin repeat (3) @(posedge clk); #1 rdy_mode = 1; end
    join
    wait_empty();

    // random backpressure stream
    rdy_mode = 2;
    for (int i = 0; i < 24; i++)
      send(2'(i % 4 == 2 ? 3 : i % 2), 32'h8000 + AW'(8*i), 64'(i*3+1), 8'(1 << (i % 8)), 0);
    rdy_mode = 1;
    wait_empty();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R2 all entries drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule